// File: doc/BRIEF.md
# Random Instruction Word Mutator

This block produces independent 32-bit instruction words for randomized processor testing. Every word starts as fresh pseudo-random bits. The block usually swaps the 7-bit major opcode for one of the base integer opcodes. Less often, it then rewrites one field with a corner-case value that suits the instruction's encoding layout. The corner cases are an extreme or near-zero immediate, an aliased register index, or a supported CSR address.

A test harness pulses or holds `req_i` and takes one word from `insn_o` in the cycle after each accepted request. Loading a seed through `seed_ld_i`/`seed_i` restarts the pseudo-random stream, so the same seed always yields the same sequence of words. The block does not check legality beyond the opcode field. It has no reference model and no multi-instruction sequence logic.

Top module: `insn_mutator`

## Requirements
- R1: While `rst` is high, and in the first cycle after a clock edge with `rst` high, `valid_o` is 0 and `insn_o` is 0, even when `req_i` is high.
- R2: A clock edge with `req_i` high and `seed_ld_i` low produces exactly one new word: `valid_o` is 1 in the following cycle. After an edge with both low, `valid_o` is 0 and `insn_o` keeps its previous value.
- R3: `seed_ld_i` takes priority over `req_i`. After an edge with `seed_ld_i` high, `valid_o` is 0. Loading the same `seed_i` twice and then requesting gives the same word stream both times.
- R4: Different seeds give different streams. A seed of zero still gives a stream whose words are not all equal.
- R5: With probability 64225/65536 (about 98 %), bits [6:0] are replaced by one of eleven opcodes: 0110111, 0010111, 1101111, 1100111, 1100011, 0000011, 0100011, 0010011, 0110011, 0001111, 1110011. Over a few thousand words at least 96 % carry one of them, and some words with other opcodes still appear.
- R6: With probability 13107/65536 (about 20 %), one field rewrite is applied after opcode selection. Most words are therefore left unmutated: at most 15 % of I-layout words carry a special immediate.
- R7: The immediate rewrite stores MIN, -1, 0, 1 or MAX of the encoded field width, signed, in the layout of the opcode. For 0000011/0010011/1100111 the immediate is bits [31:20] (values 800, FFF, 000, 001, 7FF hex). For 0110111/0010111 it is bits [31:12] (MIN 80000, MAX 7FFFF hex). At least 3 % of I-layout words carry such a value, and both 20-bit extremes occur.
- R8: The register rewrites set rd to x0, set rd to rs1, set rd to rs2, set rd and rs2 to rs1, or set rs1 to rs2. rd is bits [11:7], rs1 is bits [19:15] and rs2 is bits [24:20]. Each rewrite acts only where the layout has those fields. R-layout words (opcode 0110011) with rd = rs1 = rs2 occur.
- R9: For opcode 1110011, the immediate rewrite is replaced by writing bits [31:20] with one of the CSR addresses 300, 301, 304, 305, 340, 341, 342, 343 (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request one instruction word at this edge |
| seed_ld_i | input | 1 | Load `seed_i` into the generator state (wins over `req_i`) |
| seed_i | input | 32 | Seed value |
| valid_o | output | 1 | `insn_o` holds a word produced at the previous edge |
| insn_o | output | 32 | Generated instruction word |

## Verification
On every cycle, the assertions check the handshake timing: the reset values, one valid word after each accepted request, seed loads that never produce a word, and an output that holds while idle. The bench scenarios alone can show that a seed reproduces its stream and that distinct seeds diverge. They also cover the distributions: the share of legal opcodes, the rate of special immediates in I and U layouts, the CSR addresses on system words, and fully aliased registers on register-register words.

// File: rtl/insn_mut_pkg.sv
package insn_mut_pkg;

  localparam int unsigned XLEN   = 32;
  localparam int unsigned N_OPC  = 11;
  localparam int unsigned N_CSR  = 8;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef enum logic [2:0] {
    LAY_R, LAY_I, LAY_S, LAY_B, LAY_U, LAY_J, LAY_NONE
  } layout_e;

  typedef enum logic [2:0] {
    RW_IMM_A, RW_IMM_B, RW_RD_ZERO, RW_RD_RS1,
    RW_RD_RS2, RW_RD_BOTH, RW_RS1_RS2, RW_IMM_C
  } rewrite_e;

  function automatic logic [6:0] opc_at(logic [3:0] slot);
    case (slot)
      4'd0:    return OPC_LUI;
      4'd1:    return OPC_AUIPC;
      4'd2:    return OPC_JAL;
      4'd3:    return OPC_JALR;
      4'd4:    return OPC_BRANCH;
      4'd5:    return OPC_LOAD;
      4'd6:    return OPC_STORE;
      4'd7:    return OPC_OPIMM;
      4'd8:    return OPC_OP;
      4'd9:    return OPC_FENCE;
      default: return OPC_SYSTEM;
    endcase
  endfunction

  function automatic layout_e layout_of(logic [6:0] op);
    case (op)
      OPC_LUI, OPC_AUIPC:                        return LAY_U;
      OPC_JAL:                                   return LAY_J;
      OPC_JALR, OPC_LOAD, OPC_OPIMM,
      OPC_FENCE, OPC_SYSTEM:                     return LAY_I;
      OPC_BRANCH:                                return LAY_B;
      OPC_STORE:                                 return LAY_S;
      OPC_OP:                                    return LAY_R;
      default:                                   return LAY_NONE;
    endcase
  endfunction

  function automatic logic [11:0] csr_at(logic [2:0] k);
    case (k)
      3'd0:    return 12'h300;
      3'd1:    return 12'h301;
      3'd2:    return 12'h304;
      3'd3:    return 12'h305;
      3'd4:    return 12'h340;
      3'd5:    return 12'h341;
      3'd6:    return 12'h342;
      default: return 12'h343;
    endcase
  endfunction

  // Encoded immediate field width per layout (B and J hold offset/2).
  function automatic int unsigned imm_width(layout_e lay);
    case (lay)
      LAY_U, LAY_J: return 20;
      default:      return 12;
    endcase
  endfunction

  // Selector 0..4: MIN, -1, 0, 1, MAX of a signed field of width w.
  function automatic logic [19:0] special_val(logic [2:0] k, int unsigned w);
    logic [19:0] ones;
    logic [19:0] most_neg;
    ones     = (20'd1 << w) - 20'd1;
    most_neg = 20'd1 << (w - 1);
    case (k)
      3'd0:    return most_neg;
      3'd1:    return ones;
      3'd2:    return 20'd0;
      3'd3:    return 20'd1;
      default: return most_neg - 20'd1;
    endcase
  endfunction

endpackage

// File: rtl/insn_mut_lfsr.sv
module insn_mut_lfsr #(
  parameter int unsigned        W     = 32,
  parameter logic [W-1:0]       POLY  = 32'h8020_0003,
  parameter logic [W-1:0]       SALT  = 32'h1,
  parameter int unsigned        STEPS = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] mixed;
  logic [W-1:0] start;

  // Galois right-shift; POLY has its top bit set, so nonzero stays nonzero.
  function automatic logic [W-1:0] walk(logic [W-1:0] s);
    logic [W-1:0] t;
    t = s;
    for (int k = 0; k < int'(STEPS); k++) begin
      t = t[0] ? ((t >> 1) ^ POLY) : (t >> 1);
    end
    return t;
  endfunction

  assign mixed = seed_i ^ SALT;
  assign start = (mixed == '0) ? SALT : mixed;

  always_ff @(posedge clk) begin
    if (rst)         state_q <= SALT;
    else if (load_i) state_q <= start;
    else if (adv_i)  state_q <= walk(state_q);
  end

  assign state_o = state_q;

endmodule

// File: rtl/insn_opc_inject.sv
module insn_opc_inject
  import insn_mut_pkg::*;
#(
  parameter int unsigned DICE_W = 16,
  parameter int unsigned THRESH = 64225
) (
  input  logic [XLEN-1:0]   raw_i,
  input  logic [DICE_W-1:0] dice_i,
  input  logic [7:0]        pick_i,
  output logic [XLEN-1:0]   word_o
);

  logic [3:0] slot;
  assign slot = 4'(pick_i % 8'(N_OPC));

  always_comb begin
    word_o = raw_i;
    if (dice_i < DICE_W'(THRESH)) word_o[6:0] = opc_at(slot);
  end

endmodule

// File: rtl/insn_field_mutate.sv
module insn_field_mutate
  import insn_mut_pkg::*;
#(
  parameter int unsigned DICE_W = 16,
  parameter int unsigned THRESH = 13107
) (
  input  logic [XLEN-1:0]   word_i,
  input  logic [DICE_W-1:0] dice_i,
  input  logic [2:0]        rule_i,
  input  logic [2:0]        spec_i,
  input  logic [2:0]        csr_i,
  output logic [XLEN-1:0]   word_o
);

  layout_e     lay;
  rewrite_e    rule;
  logic        has_rd, has_rs1, has_rs2, is_sys, imm_rule;
  logic [2:0]  spec_k;
  logic [19:0] fval;

  assign lay      = layout_of(word_i[6:0]);
  assign rule     = rewrite_e'(rule_i);
  assign is_sys   = (word_i[6:0] == OPC_SYSTEM);
  assign has_rd   = lay inside {LAY_R, LAY_I, LAY_U, LAY_J};
  assign has_rs1  = lay inside {LAY_R, LAY_I, LAY_S, LAY_B};
  assign has_rs2  = lay inside {LAY_R, LAY_S, LAY_B};
  assign imm_rule = rule inside {RW_IMM_A, RW_IMM_B, RW_IMM_C};
  assign spec_k   = (spec_i >= 3'd5) ? spec_i - 3'd5 : spec_i;
  assign fval     = special_val(spec_k, imm_width(lay));

  always_comb begin
    word_o = word_i;
    if (dice_i < DICE_W'(THRESH)) begin
      if (imm_rule) begin
        if (is_sys) begin
          word_o[31:20] = csr_at(csr_i);
        end else begin
          case (lay)
            LAY_I: word_o[31:20] = fval[11:0];
            LAY_S: begin
              word_o[31:25] = fval[11:5];
              word_o[11:7]  = fval[4:0];
            end
            LAY_B: begin
              word_o[31]    = fval[11];
              word_o[7]     = fval[10];
              word_o[30:25] = fval[9:4];
              word_o[11:8]  = fval[3:0];
            end
            LAY_U: word_o[31:12] = fval;
            LAY_J: begin
              word_o[31]    = fval[19];
              word_o[19:12] = fval[18:11];
              word_o[20]    = fval[10];
              word_o[30:21] = fval[9:0];
            end
            default: ;
          endcase
        end
      end else begin
        case (rule)
          RW_RD_ZERO: if (has_rd)            word_o[11:7] = 5'd0;
          RW_RD_RS1:  if (has_rd && has_rs1) word_o[11:7] = word_i[19:15];
          RW_RD_RS2:  if (has_rd && has_rs2) word_o[11:7] = word_i[24:20];
          RW_RD_BOTH: if (has_rd && has_rs2) begin
            word_o[11:7]  = word_i[19:15];
            word_o[24:20] = word_i[19:15];
          end
          RW_RS1_RS2: if (has_rs2)           word_o[19:15] = word_i[24:20];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/insn_mutator.sv
module insn_mutator
  import insn_mut_pkg::*;
#(
  parameter int unsigned INJECT_THRESH = 64225,
  parameter int unsigned MUTATE_THRESH = 13107,
  parameter int unsigned LFSR_STEPS    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic            seed_ld_i,
  input  logic [XLEN-1:0] seed_i,
  output logic            valid_o,
  output logic [XLEN-1:0] insn_o
);

  localparam int unsigned N_LANES = 3;
  localparam int unsigned DICE_W  = 16;
  localparam logic [XLEN-1:0] POLY_TAB [N_LANES] =
    '{32'h8020_0003, 32'hA300_0000, 32'hD000_0001};
  localparam logic [XLEN-1:0] SALT_TAB [N_LANES] =
    '{32'h6D2B_79F5, 32'h1F83_D9AB, 32'h5BE0_CD19};

  logic            accept;
  logic [XLEN-1:0] lane [N_LANES];
  logic [XLEN-1:0] injected, mutated;
  logic [7:0]      pick;
  logic [2:0]      rule, spec, csr;

  assign accept = req_i && !seed_ld_i;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    insn_mut_lfsr #(
      .W(XLEN), .POLY(POLY_TAB[g]), .SALT(SALT_TAB[g]), .STEPS(LFSR_STEPS)
    ) u_lfsr (
      .clk(clk), .rst(rst), .load_i(seed_ld_i), .seed_i(seed_i),
      .adv_i(accept), .state_o(lane[g])
    );
  end

  // Lane 0: raw word; lane 1: inject dice and opcode pick; lane 2: rewrite.
  assign pick = lane[1][23:16] ^ lane[1][31:24];
  assign rule = lane[2][18:16] ^ {2'b00, lane[2][31]};
  assign spec = lane[2][21:19] ^ lane[2][30:28];
  assign csr  = lane[2][24:22] ^ lane[2][27:25];

  insn_opc_inject #(.DICE_W(DICE_W), .THRESH(INJECT_THRESH)) u_inject (
    .raw_i(lane[0]), .dice_i(lane[1][DICE_W-1:0]), .pick_i(pick),
    .word_o(injected)
  );

  insn_field_mutate #(.DICE_W(DICE_W), .THRESH(MUTATE_THRESH)) u_mutate (
    .word_i(injected), .dice_i(lane[2][DICE_W-1:0]), .rule_i(rule),
    .spec_i(spec), .csr_i(csr), .word_o(mutated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      insn_o  <= '0;
    end else begin
      valid_o <= accept;
      if (accept) insn_o <= mutated;
    end
  end

endmodule

// File: rtl/insn_mut_chk.sv
module insn_mut_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_i,
  input logic        seed_ld_i,
  input logic        valid_o,
  input logic [31:0] insn_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && insn_o == 32'd0));

  // R2
  word_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && !seed_ld_i) |=> valid_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_i && !seed_ld_i) |=> (!valid_o && $stable(insn_o)));

  // R3
  seed_no_word_chk: assert property (@(posedge clk) disable iff (rst)
    seed_ld_i |=> !valid_o);

endmodule

bind insn_mutator insn_mut_chk u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .seed_ld_i(seed_ld_i),
  .valid_o(valid_o), .insn_o(insn_o)
);

// File: tb/insn_mutator_bench.sv
module insn_mutator_bench;

  logic        clk = 1'b0;
  logic        rst, req, seed_ld;
  logic [31:0] seed;
  logic        valid;
  logic [31:0] insn;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  insn_mutator u_insn_mutator (
    .clk(clk), .rst(rst), .req_i(req), .seed_ld_i(seed_ld), .seed_i(seed),
    .valid_o(valid), .insn_o(insn)
  );

  localparam int SEEDS_N = 3;
  localparam int WORDS_PER_SEED = 2000;
  localparam logic [31:0] SEED_TAB [SEEDS_N] =
    '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0BAD_F00D};

  logic [31:0] cap [3][16];
  int n_all, n_legal, n_i, i_hit, u_min, u_max, csr_hit, alias_hit;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic load_seed(input logic [31:0] v);
    @(negedge clk);
    req = 1'b0; seed_ld = 1'b1; seed = v;
    @(negedge clk);
    seed_ld = 1'b0;
    check(valid == 1'b0, "R3 no word after seed load", {31'd0, valid}, 32'd0);
  endtask

  task automatic capture(input int slot);
    req = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cap[slot][i] = insn;
    end
    req = 1'b0;
  endtask

  function automatic bit is_legal(logic [6:0] op);
    return op inside {7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111,
                      7'b1100011, 7'b0000011, 7'b0100011, 7'b0010011,
                      7'b0110011, 7'b0001111, 7'b1110011};
  endfunction

  task automatic classify(input logic [31:0] w);
    n_all++;
    if (is_legal(w[6:0])) n_legal++;
    if (w[6:0] inside {7'b0000011, 7'b0010011, 7'b1100111}) begin
      n_i++;
      if (w[31:20] inside {12'h800, 12'hFFF, 12'h000, 12'h001, 12'h7FF}) i_hit++;
    end
    if (w[6:0] inside {7'b0110111, 7'b0010111}) begin
      if (w[31:12] == 20'h80000) u_min++;
      if (w[31:12] == 20'h7FFFF) u_max++;
    end
    if (w[6:0] == 7'b1110011 &&
        w[31:20] inside {12'h300, 12'h301, 12'h304, 12'h305,
                         12'h340, 12'h341, 12'h342, 12'h343}) csr_hit++;
    if (w[6:0] == 7'b0110011 && w[11:7] == w[19:15] && w[19:15] == w[24:20])
      alias_hit++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] w0;
    bit same, differ, varied;
    rst = 1'b1; req = 1'b0; seed_ld = 1'b0; seed = '0;
    n_all = 0; n_legal = 0; n_i = 0; i_hit = 0; u_min = 0; u_max = 0;
    csr_hit = 0; alias_hit = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(valid == 1'b0, "R1 valid in reset", {31'd0, valid}, 32'd0);
    check(insn == 32'd0, "R1 insn in reset", insn, 32'd0);
    rst = 1'b0;

    // R2 single request, then idle hold
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(valid == 1'b1, "R2 valid after request", {31'd0, valid}, 32'd1);
    w0 = insn;
    @(negedge clk);
    check(valid == 1'b0, "R2 valid drops when idle", {31'd0, valid}, 32'd0);
    check(insn == w0, "R2 word held when idle", insn, w0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check(insn != w0, "R2 new word per request", insn, ~w0);

    // R3 reproducibility
    load_seed(32'hCAFE_0001); capture(0);
    load_seed(32'hCAFE_0001); capture(1);
    same = 1'b1;
    for (int i = 0; i < 16; i++) if (cap[0][i] != cap[1][i]) same = 1'b0;
    check(same, "R3 same seed same stream", cap[1][15], cap[0][15]);

    // R4 distinct seed and zero seed
    load_seed(32'hCAFE_0002); capture(2);
    differ = 1'b0;
    for (int i = 0; i < 16; i++) if (cap[0][i] != cap[2][i]) differ = 1'b1;
    check(differ, "R4 distinct seeds diverge", cap[2][0], ~cap[0][0]);
    load_seed(32'd0); capture(2);
    varied = 1'b0;
    for (int i = 1; i < 16; i++) if (cap[2][i] != cap[2][0]) varied = 1'b1;
    check(varied, "R4 zero seed stream varies", cap[2][1], ~cap[2][0]);

    // Stream vectors walked from the seed table (R5..R9 statistics)
    for (int s = 0; s < SEEDS_N; s++) begin
      load_seed(SEED_TAB[s]);
      req = 1'b1;
      for (int i = 0; i < WORDS_PER_SEED; i++) begin
        @(negedge clk);
        if (valid !== 1'b1)
          check(1'b0, "R2 valid during stream", {31'd0, valid}, 32'd1);
        classify(insn);
      end
      req = 1'b0;
    end
    check(n_legal * 100 >= n_all * 96, "R5 legal opcode share",
          n_legal, n_all * 96 / 100);
    check(n_all - n_legal >= 20, "R5 some opcodes left random",
          n_all - n_legal, 20);
    check(i_hit * 100 <= n_i * 15, "R6 most words unmutated", i_hit, n_i * 15 / 100);
    check(i_hit * 100 >= n_i * 3, "R7 I-layout special immediates", i_hit, n_i * 3 / 100);
    check(u_min >= 1, "R7 20-bit MIN seen", u_min, 1);
    check(u_max >= 1, "R7 20-bit MAX seen", u_max, 1);
    check(alias_hit >= 4, "R8 rd=rs1=rs2 on R-layout", alias_hit, 4);
    check(csr_hit >= 10, "R9 supported CSR addresses", csr_hit, 10);

    // R3 priority of seed load over request
    @(negedge clk); req = 1'b1; seed_ld = 1'b1; seed = 32'h55AA_55AA;
    @(negedge clk); req = 1'b0; seed_ld = 1'b0;
    check(valid == 1'b0, "R3 seed load wins over request", {31'd0, valid}, 32'd0);

    // R1 reset while requesting
    @(negedge clk); req = 1'b1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R1 reset over request valid", {31'd0, valid}, 32'd0);
    check(insn == 32'd0, "R1 reset over request insn", insn, 32'd0);
    req = 1'b0; rst = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule